// File: doc/BRIEF.md
# Display FIFO Refill Requester

This block decides when a display layer's pixel FIFO should ask the memory interconnect for another burst of data. It compares the FIFO fill level against two programmable thresholds and applies hysteresis. Once the level has dropped to the low threshold, the block enters a refill phase and issues burst read requests. The phase ends when the level reaches the high threshold. After that the block stays quiet until the level falls back to the low threshold.

Each request is also gated by a room check. The free space is taken as the FIFO capacity, minus the current level, minus the words already requested but not yet returned. A request goes out only when that space can absorb a full burst. An internal counter tracks those outstanding words.

When the merge input is set, the three layer FIFOs act as one store for the single active layer. The capacity used by the room check then triples. Software is expected to program both thresholds at three times their normal values in that mode. While the layer is disabled, no requests are made.

Top module: `fifo_refill_req`

## Requirements
- R1: The low threshold is taken from bits [11:0] of `thr_reg` and the high threshold from bits [27:16]; every other bit of `thr_reg` has no effect.
- R2: With the layer enabled and outside a refill phase, a fill level less than or equal to the low threshold starts a refill phase at the next clock edge. `req_valid` can rise in the cycle after that edge. A level one above the low threshold does not start a phase.
- R3: `req_valid` is high only when capacity − `fill_level` − `pending_words` ≥ `BURST_LEN`.
- R4: A refill phase ends at the clock edge after `fill_level` reaches or exceeds the high threshold. No new phase starts until the level is again at or below the low threshold. Within a phase, no request is raised while `fill_level` + `pending_words` is at or above the high threshold.
- R5: `pending_words` rises by `BURST_LEN` at each edge where `req_valid` and `req_grant` are both high. It falls by one at each edge where `ret_valid` is high.
- R6: The capacity is `FIFO_DEPTH` when `merge_en` = 0 and 3 × `FIFO_DEPTH` when `merge_en` = 1.
- R7: While `layer_en` is low, `req_valid` is low and any refill phase is abandoned. Re-enabling with the level above the low threshold does not resume requests.
- R8: After reset, `req_valid` is low, `pending_words` is zero and no refill phase is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layer_en | input | 1 | Layer enable; requests only when high |
| merge_en | input | 1 | Three FIFOs joined into one (capacity ×3) |
| thr_reg | input | 32 | Threshold word: low at [11:0], high at [27:16] |
| fill_level | input | LVL_W | Current FIFO occupancy in words |
| req_valid | output | 1 | Burst read request |
| req_grant | input | 1 | Interconnect accepts the request this cycle |
| ret_valid | input | 1 | One requested word returned this cycle |
| pending_words | output | LVL_W | Words requested but not yet returned |

## Verification
The bench probes the threshold boundaries: a level equal to the low threshold must start a refill and a level one above must not. A design using a strict compare would stall at exactly the threshold. The room check is driven to exactly one burst of free space and to one word less. This catches a design that ignores outstanding data, which would overrun the FIFO, or one that is off by one and loses a burst slot. The bench also sweeps the level through the band between the thresholds, where a design without hysteresis would chatter requests. Finally, it toggles the layer enable and the merge bit, and sets stray bits in the threshold word. These steps expose a design that resumes a stale phase, keeps single-FIFO capacity after merging, or decodes the wrong field.

// File: rtl/frq_pkg.sv
package frq_pkg;

  // Low threshold field of the threshold word.
  function automatic logic [11:0] thr_low(input logic [31:0] word);
    return word[11:0];
  endfunction

  // High threshold field of the threshold word.
  function automatic logic [11:0] thr_high(input logic [31:0] word);
    return word[27:16];
  endfunction

  // Usable storage in words for one layer, tripled when FIFOs are joined.
  function automatic int eff_capacity(input int depth, input logic merged);
    return merged ? 3 * depth : depth;
  endfunction

  // True when one more burst fits on top of the level and in-flight data.
  function automatic logic burst_fits(input int cap, input int lvl,
                                      input int inflight, input int burst);
    return (cap - lvl - inflight) >= burst;
  endfunction

endpackage

// File: rtl/frq_room.sv
module frq_room #(
  parameter int FIFO_DEPTH = 1024,
  parameter int BURST_LEN  = 16,
  parameter int LVL_W      = 12
) (
  input  logic             merge_en,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] pending_words,
  input  logic [11:0]      high_thr,
  output logic             room_ok,
  output logic             under_high
);
  import frq_pkg::*;

  int cap;
  int projected;

  always_comb begin
    cap        = eff_capacity(FIFO_DEPTH, merge_en);
    projected  = int'(fill_level) + int'(pending_words);
    room_ok    = burst_fits(cap, int'(fill_level), int'(pending_words), BURST_LEN);
    under_high = projected < int'(high_thr);
  end
endmodule

// File: rtl/frq_hyst.sv
module frq_hyst #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_en,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [11:0]      low_thr,
  input  logic [11:0]      high_thr,
  output logic             filling,
  output logic             start_evt,
  output logic             stop_evt
);
  logic at_or_below_low;
  logic at_or_above_high;

  assign at_or_below_low  = int'(fill_level) <= int'(low_thr);
  assign at_or_above_high = int'(fill_level) >= int'(high_thr);
  assign start_evt        = layer_en && !filling && at_or_below_low;
  assign stop_evt         = filling && (at_or_above_high || !layer_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         filling <= 1'b0;
    else if (start_evt) filling <= 1'b1;
    else if (stop_evt)  filling <= 1'b0;
  end

  // R2: low level with layer enabled opens a refill phase
  p_start_at_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_en && !filling && at_or_below_low) |=> filling);

  // R4: reaching high ends the phase
  p_stop_at_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filling && at_or_above_high) |=> !filling);

  // R4: idle stays idle while above low
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && !at_or_below_low) |=> !filling);

  // R7: disable abandons the phase
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !layer_en |=> !filling);
endmodule

// File: rtl/frq_pending.sv
module frq_pending #(
  parameter int BURST_LEN = 16,
  parameter int LVL_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ret_valid,
  output logic [LVL_W-1:0] pending_words
);
  localparam logic [LVL_W-1:0] INC = LVL_W'(BURST_LEN);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic [LVL_W-1:0] nxt;

  always_comb begin
    nxt = pending_words;
    if (accept)    nxt = nxt + INC;
    if (ret_valid) nxt = nxt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_words <= '0;
    else        pending_words <= nxt;
  end

  // R5: an accepted burst without a return adds one burst
  p_pend_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ret_valid) |=> pending_words == $past(pending_words) + INC);

  // R5: a return without a grant removes one word
  p_pend_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && ret_valid) |=> pending_words == $past(pending_words) - ONE);
endmodule

// File: rtl/fifo_refill_req.sv
module fifo_refill_req #(
  parameter int FIFO_DEPTH = 1024,
  parameter int BURST_LEN  = 16,
  parameter int LVL_W      = $clog2(3 * FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_en,
  input  logic             merge_en,
  input  logic [31:0]      thr_reg,
  input  logic [LVL_W-1:0] fill_level,
  output logic             req_valid,
  input  logic             req_grant,
  input  logic             ret_valid,
  output logic [LVL_W-1:0] pending_words
);
  import frq_pkg::*;

  logic [11:0] low_thr;
  logic [11:0] high_thr;
  logic        filling;
  logic        start_evt;
  logic        stop_evt;
  logic        room_ok;
  logic        under_high;
  logic        accept;

  assign low_thr  = thr_low(thr_reg);
  assign high_thr = thr_high(thr_reg);

  frq_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .layer_en   (layer_en),
    .fill_level (fill_level),
    .low_thr    (low_thr),
    .high_thr   (high_thr),
    .filling    (filling),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt)
  );

  frq_room #(.FIFO_DEPTH(FIFO_DEPTH), .BURST_LEN(BURST_LEN), .LVL_W(LVL_W)) u_room (
    .merge_en      (merge_en),
    .fill_level    (fill_level),
    .pending_words (pending_words),
    .high_thr      (high_thr),
    .room_ok       (room_ok),
    .under_high    (under_high)
  );

  assign req_valid = layer_en && filling && room_ok && under_high;
  assign accept    = req_valid && req_grant;

  frq_pending #(.BURST_LEN(BURST_LEN), .LVL_W(LVL_W)) u_pend (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .ret_valid     (ret_valid),
    .pending_words (pending_words)
  );

  // R3, R6: a raised request never overfills the effective capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(fill_level) + int'(pending_words) + BURST_LEN)
                  <= (merge_en ? 3 * FIFO_DEPTH : FIFO_DEPTH));

  // R7: nothing is requested while the layer is off
  p_idle_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !layer_en |-> !req_valid);

  // R4: a request never pushes projected data past the high threshold
  p_below_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(fill_level) + int'(pending_words)) < int'(thr_reg[27:16]));
endmodule

// File: tb/tb_fifo_refill_req.sv
module tb_fifo_refill_req;
  localparam int DEPTH = 1024;
  localparam int BURST = 16;
  localparam int LW    = $clog2(3 * DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          layer_en = 1'b0;
  logic          merge_en = 1'b0;
  logic [31:0]   thr_reg = '0;
  logic [LW-1:0] fill_level = '0;
  logic          req_valid;
  logic          req_grant = 1'b0;
  logic          ret_valid = 1'b0;
  logic [LW-1:0] pending_words;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fifo_refill_req #(.FIFO_DEPTH(DEPTH), .BURST_LEN(BURST)) dut (
    .clk(clk), .rst_n(rst_n), .layer_en(layer_en), .merge_en(merge_en),
    .thr_reg(thr_reg), .fill_level(fill_level), .req_valid(req_valid),
    .req_grant(req_grant), .ret_valid(ret_valid), .pending_words(pending_words)
  );

  function automatic logic [31:0] mk_thr(input int lo, input int hi);
    return {4'h0, 12'(hi), 4'h0, 12'(lo)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R8 req after reset", int'(req_valid), 0);
    chk("R8 pending after reset", int'(pending_words), 0);
  endtask

  task automatic t_start();
    thr_reg = mk_thr(100, 800); layer_en = 1'b1; fill_level = 500; tick();
    chk("R4 idle above low", int'(req_valid), 0);
    fill_level = 101; tick();
    chk("R2 low+1 no start", int'(req_valid), 0);
    fill_level = 100; tick();
    chk("R2 start at low", int'(req_valid), 1);
  endtask

  task automatic t_grant();
    req_grant = 1'b1; tick(); req_grant = 1'b0;
    chk("R5 pending after grant", int'(pending_words), 16);
    ret_valid = 1'b1; tick(); tick(); tick(); ret_valid = 1'b0;
    chk("R5 pending after returns", int'(pending_words), 13);
  endtask

  task automatic t_room();
    thr_reg = mk_thr(1010, 2000); fill_level = 1000; tick();
    chk("R3 free 11 < burst", int'(req_valid), 0);
    fill_level = 995; tick();
    chk("R3 free exactly burst", int'(req_valid), 1);
    fill_level = 996; tick();
    chk("R3 free burst-1", int'(req_valid), 0);
    merge_en = 1'b1; fill_level = 1000; tick();
    chk("R6 merged capacity", int'(req_valid), 1);
    merge_en = 1'b0; tick();
    chk("R6 single capacity", int'(req_valid), 0);
  endtask

  task automatic t_hyst();
    thr_reg = mk_thr(100, 300); fill_level = 300; tick();
    chk("R4 stop at high", int'(req_valid), 0);
    fill_level = 200; tick();
    chk("R4 no restart in band", int'(req_valid), 0);
    fill_level = 100; tick();
    chk("R4 restart at low", int'(req_valid), 1);
    fill_level = 290; tick();
    chk("R4 projected reaches high", int'(req_valid), 0);
    fill_level = 280; tick();
    chk("R4 projected below high", int'(req_valid), 1);
  endtask

  task automatic t_disable();
    layer_en = 1'b0; tick();
    chk("R7 disabled no req", int'(req_valid), 0);
    fill_level = 200; layer_en = 1'b1; tick();
    chk("R7 phase abandoned", int'(req_valid), 0);
  endtask

  task automatic t_decode();
    thr_reg = 32'hF000_C000 | mk_thr(150, 500); tick();
    chk("R1 stray bits idle", int'(req_valid), 0);
    fill_level = 151; tick();
    chk("R1 low field +1", int'(req_valid), 0);
    fill_level = 150; tick();
    chk("R1 low field hit", int'(req_valid), 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_start();
    t_grant();
    t_room();
    t_hyst();
    t_disable();
    t_decode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule